// File: doc/BRIEF.md
# Storage Port Error Classifier

This block sorts the error events of one serial storage host adapter port into sticky per-port status bits and works out what the port does next. It receives memory-side errors (an abort, or a data error such as parity or CRC), each tagged with what was being fetched at the time. It also receives link-side errors, each tagged with whether a data frame or some other frame was in flight, and it watches the link-ready level. Each event lands in one of four status bits. From the event kind and the fetch or frame tag, the block decides three things: whether command processing must halt, whether later outgoing data frames must carry a corrupted CRC, and whether a failed non-data frame is queued for another attempt.

Software reads the status bits and clears them by writing ones. A level interrupt is raised when an enabled status bit is set and the global enable is on. After a halting error, command processing resumes only when software has cleared every fatal status bit and then pulses the restart input. A queued retry waits while the device is still sending frames to the port, and it is issued once the port is idle. Every status bit belongs to this one port, and no status is shared with other ports.

Top module: `sperr_classifier`

## Requirements
- R1: While reset is high, and in the first cycle after it, status, irq, stop_req, poison_crc, retry_pend and retry_fire are all 0.
- R2: A memory event with mem_err_data=0 (an abort) sets status bit 0 and stop_req on the following clock edge.
- R3: A memory data event (mem_err_data=1) sets status bit 1 and stop_req on the following edge when its source code is a fetch: 0 command frame, 1 descriptor entry, 2 command list. Codes 5 to 7 are treated as fetches.
- R4: A memory data event with source 3 (payload) or 4 (packet command field) sets status bit 1 without stop_req, and sets poison_crc. poison_crc stays set until xfer_end is high at a clock edge that brings no new such event.
- R5: A link event whose cause vector is non-zero, with cause bit 0 = protocol, bit 1 = CRC diagnostic and bit 2 = handshake diagnostic, sets status bit 2 and stop_req when lnk_data_frm=1. A link event whose cause vector is zero has no effect.
- R6: The same link event with lnk_data_frm=0 sets status bit 3 and retry_pend, and leaves stop_req unchanged.
- R7: link_ready falling from 1 to 0 while link_down_ok=0 counts as a link event and is sorted by lnk_data_frm as in R5 and R6. The same fall while link_down_ok=1 has no effect.
- R8: retry_pend stays set for as long as dev_busy is high. In the first cycle in which dev_busy is low, retry_fire pulses for one cycle on the next edge and retry_pend clears.
- R9: Status bits are sticky. A bit clears only when clr_we is high with its clr_bits bit at 1. A new event in the same cycle as its clear leaves the bit set, and bits whose clr_bits bit is 0 are unaffected.
- R10: stop_req clears only on an edge where port_restart is high while status bits 0 to 2 already read 0. A restart in any other cycle has no effect.
- R11: irq is registered: irq equals gie AND the OR of (status AND irq_en), as that value stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_err_vld | input | 1 | Memory error event this cycle |
| mem_err_data | input | 1 | 1 = data error, 0 = abort |
| mem_err_src | input | 3 | Fetch source code of the memory error |
| lnk_err_vld | input | 1 | Link error event this cycle |
| lnk_cause | input | NCAUSE | Link error cause bits |
| lnk_data_frm | input | 1 | 1 = data frame in flight |
| link_ready | input | 1 | Physical link ready level |
| link_down_ok | input | 1 | A link-ready drop is expected |
| dev_busy | input | 1 | Device frame reception in progress |
| xfer_end | input | 1 | Current outgoing transfer finished |
| clr_we | input | 1 | Status clear strobe |
| clr_bits | input | 4 | Write-one-to-clear mask |
| irq_en | input | 4 | Per-status interrupt enables |
| gie | input | 1 | Global interrupt enable |
| port_restart | input | 1 | Software restart pulse |
| status | output | 4 | Bit 0 abort, 1 memory data, 2 fatal link, 3 non-fatal link |
| irq | output | 1 | Interrupt level |
| stop_req | output | 1 | Halt command processing |
| poison_crc | output | 1 | Corrupt CRC of outgoing data frames |
| retry_pend | output | 1 | Failed non-data frame awaiting retry |
| retry_fire | output | 1 | One-cycle pulse to issue the retry |

## Verification
Several properties are checked on every cycle of any run: the routing of aborts, fetch data errors and link errors to their status bits and to the stop request, the stickiness of each status bit, the interrupt's one-cycle relation to status and enables, that a retry pulse only follows a pending retry with the device idle, and that the stop request only drops after a restart. Other behaviours need set-up sequences that only the bench's scenarios provide. These are the continue-and-poison path and its end at the transfer boundary, the expected versus unexpected link drop, a clear that coincides with a new event, and a restart refused while a fatal bit is still set.

// File: rtl/sperr_pkg.sv
package sperr_pkg;

  localparam int NSTAT = 4;

  localparam int ST_HABT = 0;
  localparam int ST_HDAT = 1;
  localparam int ST_IFAT = 2;
  localparam int ST_INF  = 3;

  localparam logic [NSTAT-1:0] FATAL_MASK = 4'b0111;

  typedef enum logic [2:0] {
    SRC_CMDFRM  = 3'd0,
    SRC_DESC    = 3'd1,
    SRC_CLIST   = 3'd2,
    SRC_PAYLOAD = 3'd3,
    SRC_PKTCMD  = 3'd4
  } mem_src_e;

  typedef struct packed {
    logic habt;
    logic hdat_stop;
    logic hdat_cont;
    logic ifat;
    logic inf;
  } err_class_t;

endpackage

// File: rtl/sperr_route.sv
module sperr_route
  import sperr_pkg::*;
#(
  parameter int NCAUSE        = 3,
  parameter bit CONT_DATA_ERR = 1'b1
) (
  input  logic              mem_vld,
  input  logic              mem_is_data,
  input  logic [2:0]        mem_src,
  input  logic              lnk_vld,
  input  logic [NCAUSE-1:0] lnk_cause,
  input  logic              lnk_data_frm,
  input  logic              link_drop,
  output err_class_t        cls
);

  logic payload_src;
  logic mem_data;
  logic iface;

  // payload and packet-command field may continue; everything else is a fetch
  assign payload_src = (mem_src == SRC_PAYLOAD) || (mem_src == SRC_PKTCMD);
  assign mem_data    = mem_vld & mem_is_data;
  assign iface       = (lnk_vld & (|lnk_cause)) | link_drop;

  assign cls.habt = mem_vld & ~mem_is_data;
  assign cls.ifat = iface & lnk_data_frm;
  assign cls.inf  = iface & ~lnk_data_frm;

  generate
    if (CONT_DATA_ERR) begin : g_cont
      assign cls.hdat_stop = mem_data & ~payload_src;
      assign cls.hdat_cont = mem_data & payload_src;
    end else begin : g_halt
      assign cls.hdat_stop = mem_data;
      assign cls.hdat_cont = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sperr_w1c.sv
module sperr_w1c #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] st
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) st[g] <= 1'b0;
      else     st[g] <= (st[g] & ~(clr_we & clr_bits[g])) | set[g];
    end
  end

endmodule

// File: rtl/sperr_irq.sv
module sperr_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] st,
  input  logic [N-1:0] en,
  input  logic         gie,
  output logic         irq
);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= gie & (|(st & en));
  end

endmodule

// File: rtl/sperr_retry.sv
module sperr_retry (
  input  logic clk,
  input  logic rst,
  input  logic set_pend,
  input  logic dev_busy,
  output logic pend,
  output logic fire
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= pend & ~dev_busy;
      pend <= set_pend | (pend & dev_busy);
    end
  end

endmodule

// File: rtl/sperr_classifier.sv
module sperr_classifier
  import sperr_pkg::*;
#(
  parameter int NCAUSE        = 3,
  parameter bit CONT_DATA_ERR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_err_vld,
  input  logic              mem_err_data,
  input  logic [2:0]        mem_err_src,
  input  logic              lnk_err_vld,
  input  logic [NCAUSE-1:0] lnk_cause,
  input  logic              lnk_data_frm,
  input  logic              link_ready,
  input  logic              link_down_ok,
  input  logic              dev_busy,
  input  logic              xfer_end,
  input  logic              clr_we,
  input  logic [NSTAT-1:0]  clr_bits,
  input  logic [NSTAT-1:0]  irq_en,
  input  logic              gie,
  input  logic              port_restart,
  output logic [NSTAT-1:0]  status,
  output logic              irq,
  output logic              stop_req,
  output logic              poison_crc,
  output logic              retry_pend,
  output logic              retry_fire
);

  err_class_t       cls;
  logic             link_prev;
  logic             link_drop;
  logic [NSTAT-1:0] set_vec;
  logic             stop_trig;

  always_ff @(posedge clk) begin
    if (rst) link_prev <= 1'b0;
    else     link_prev <= link_ready;
  end

  assign link_drop = link_prev & ~link_ready & ~link_down_ok;

  sperr_route #(.NCAUSE(NCAUSE), .CONT_DATA_ERR(CONT_DATA_ERR)) u_route (
    .mem_vld      (mem_err_vld),
    .mem_is_data  (mem_err_data),
    .mem_src      (mem_err_src),
    .lnk_vld      (lnk_err_vld),
    .lnk_cause    (lnk_cause),
    .lnk_data_frm (lnk_data_frm),
    .link_drop    (link_drop),
    .cls          (cls)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_HABT] = cls.habt;
    set_vec[ST_HDAT] = cls.hdat_stop | cls.hdat_cont;
    set_vec[ST_IFAT] = cls.ifat;
    set_vec[ST_INF]  = cls.inf;
  end

  assign stop_trig = cls.habt | cls.hdat_stop | cls.ifat;

  sperr_w1c #(.N(NSTAT)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .set      (set_vec),
    .clr_we   (clr_we),
    .clr_bits (clr_bits),
    .st       (status)
  );

  sperr_irq #(.N(NSTAT)) u_irq (
    .clk (clk),
    .rst (rst),
    .st  (status),
    .en  (irq_en),
    .gie (gie),
    .irq (irq)
  );

  sperr_retry u_retry (
    .clk      (clk),
    .rst      (rst),
    .set_pend (cls.inf),
    .dev_busy (dev_busy),
    .pend     (retry_pend),
    .fire     (retry_fire)
  );

  // halt holds until fatal bits read clear and software restarts the port
  always_ff @(posedge clk) begin
    if (rst)                                              stop_req <= 1'b0;
    else if (stop_trig)                                   stop_req <= 1'b1;
    else if (port_restart && ((status & FATAL_MASK) == '0)) stop_req <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                poison_crc <= 1'b0;
    else if (cls.hdat_cont) poison_crc <= 1'b1;
    else if (xfer_end)      poison_crc <= 1'b0;
  end

endmodule

// File: rtl/sperr_chk.sv
module sperr_chk
  import sperr_pkg::*;
#(
  parameter int NCAUSE = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_err_vld,
  input logic              mem_err_data,
  input logic [2:0]        mem_err_src,
  input logic              lnk_err_vld,
  input logic [NCAUSE-1:0] lnk_cause,
  input logic              lnk_data_frm,
  input logic              dev_busy,
  input logic              clr_we,
  input logic [NSTAT-1:0]  clr_bits,
  input logic [NSTAT-1:0]  irq_en,
  input logic              gie,
  input logic              port_restart,
  input logic [NSTAT-1:0]  status,
  input logic              irq,
  input logic              stop_req,
  input logic              retry_pend,
  input logic              retry_fire
);

  // R2
  abort_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_err_vld && !mem_err_data) |=> (status[ST_HABT] && stop_req));

  // R3
  fetch_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_err_vld && mem_err_data && (mem_err_src <= 3'd2)) |=> (status[ST_HDAT] && stop_req));

  // R5
  data_frm_fatal_chk: assert property (@(posedge clk) disable iff (rst)
    (lnk_err_vld && (|lnk_cause) && lnk_data_frm) |=> (status[ST_IFAT] && stop_req));

  // R6
  nondata_retry_chk: assert property (@(posedge clk) disable iff (rst)
    (lnk_err_vld && (|lnk_cause) && !lnk_data_frm) |=> (status[ST_INF] && retry_pend));

  // R8
  fire_source_chk: assert property (@(posedge clk) disable iff (rst)
    retry_fire |-> ($past(retry_pend) && !$past(dev_busy)));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_req) |-> $past(port_restart));

  // R11
  irq_timing_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past(gie && (|(status & irq_en))));

  for (genvar k = 0; k < NSTAT; k++) begin : g_sticky
    // R9
    sticky_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (status[k] && !(clr_we && clr_bits[k])) |=> status[k]);
  end

endmodule

bind sperr_classifier sperr_chk #(.NCAUSE(NCAUSE)) u_chk (.*);

// File: tb/tb_sperr_classifier.sv
module tb_sperr_classifier;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // {mem_vld, mem_data, src[2:0], lnk_vld, cause[2:0], lnk_data,
  //  exp_status[3:0], exp_stop, exp_poison, exp_pend}
  localparam logic [16:0] VEC [NVEC] = '{
    17'b1_0_000_0_000_0_0001_1_0_0,  // R2 abort
    17'b1_1_000_0_000_0_0010_1_0_0,  // R3 command frame fetch
    17'b1_1_001_0_000_0_0010_1_0_0,  // R3 descriptor fetch
    17'b1_1_010_0_000_0_0010_1_0_0,  // R3 command list fetch
    17'b1_1_011_0_000_0_0010_0_1_0,  // R4 payload
    17'b1_1_100_0_000_0_0010_0_1_0,  // R4 packet command field
    17'b0_0_000_1_001_1_0100_1_0_0,  // R5 protocol, data frame
    17'b0_0_000_1_010_0_1000_0_0_1,  // R6 crc diag, non-data
    17'b0_0_000_1_100_0_1000_0_0_1,  // R6 handshake diag, non-data
    17'b0_0_000_1_000_1_0000_0_0_0,  // R5 zero cause ignored
    17'b1_0_000_1_001_0_1001_1_0_1   // R2 and R6 together
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       mem_err_vld, mem_err_data;
  logic [2:0] mem_err_src;
  logic       lnk_err_vld;
  logic [2:0] lnk_cause;
  logic       lnk_data_frm, link_ready, link_down_ok, dev_busy, xfer_end;
  logic       clr_we;
  logic [3:0] clr_bits, irq_en;
  logic       gie, port_restart;
  logic [3:0] status;
  logic       irq, stop_req, poison_crc, retry_pend, retry_fire;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sperr_classifier dut (
    .clk(clk), .rst(rst),
    .mem_err_vld(mem_err_vld), .mem_err_data(mem_err_data), .mem_err_src(mem_err_src),
    .lnk_err_vld(lnk_err_vld), .lnk_cause(lnk_cause), .lnk_data_frm(lnk_data_frm),
    .link_ready(link_ready), .link_down_ok(link_down_ok), .dev_busy(dev_busy),
    .xfer_end(xfer_end), .clr_we(clr_we), .clr_bits(clr_bits), .irq_en(irq_en),
    .gie(gie), .port_restart(port_restart),
    .status(status), .irq(irq), .stop_req(stop_req), .poison_crc(poison_crc),
    .retry_pend(retry_pend), .retry_fire(retry_fire)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    mem_err_vld = 0; mem_err_data = 0; mem_err_src = 0;
    lnk_err_vld = 0; lnk_cause = 0; lnk_data_frm = 0;
    xfer_end = 0; clr_we = 0; clr_bits = 0; port_restart = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // clear all status, end transfer, then restart; leaves port idle
  task automatic recover();
    idle_inputs();
    clr_we = 1; clr_bits = 4'hF; xfer_end = 1;
    cyc();
    idle_inputs();
    port_restart = 1;
    cyc();
    idle_inputs();
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; idle_inputs();
    link_ready = 1; link_down_ok = 0; dev_busy = 0;
    irq_en = 4'hF; gie = 1;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 status", status, 0);
    chk("R1 outs", {irq, stop_req, poison_crc, retry_pend, retry_fire}, 0);
    rst = 0;
    cyc();
    chk("R1 after release", {status, irq, stop_req, poison_crc, retry_pend, retry_fire}, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      mem_err_vld  = VEC[i][16];
      mem_err_data = VEC[i][15];
      mem_err_src  = VEC[i][14:12];
      lnk_err_vld  = VEC[i][11];
      lnk_cause    = VEC[i][10:8];
      lnk_data_frm = VEC[i][7];
      cyc();
      idle_inputs();
      chk($sformatf("R2-R6 vec%0d status", i), status, VEC[i][6:3]);
      chk($sformatf("R2/R3/R5 vec%0d stop", i), stop_req, VEC[i][2]);
      chk($sformatf("R4 vec%0d poison", i), poison_crc, VEC[i][1]);
      chk($sformatf("R6 vec%0d pend", i), retry_pend, VEC[i][0]);
      cyc();
      chk($sformatf("R11 vec%0d irq", i), irq, (VEC[i][6:3] != 0));
      recover();
    end

    // R4 poison holds until transfer end
    mem_err_vld = 1; mem_err_data = 1; mem_err_src = 3'd3;
    cyc(); idle_inputs();
    repeat (3) cyc();
    chk("R4 poison holds", poison_crc, 1);
    xfer_end = 1; cyc(); idle_inputs();
    chk("R4 poison cleared by xfer_end", poison_crc, 0);
    recover();

    // R7 unexpected link drop during data frame
    lnk_data_frm = 1; link_ready = 0;
    cyc(); idle_inputs();
    chk("R7 drop data frame status", status, 4'b0100);
    chk("R7 drop data frame stop", stop_req, 1);
    link_ready = 1; cyc(); recover();
    // R7 unexpected drop during non-data frame
    link_ready = 0; lnk_data_frm = 0;
    cyc(); idle_inputs();
    chk("R7 drop non-data status", status, 4'b1000);
    chk("R7 drop non-data pend", retry_pend, 1);
    link_ready = 1; cyc(); recover();
    // R7 expected drop ignored
    link_down_ok = 1; link_ready = 0; lnk_data_frm = 1;
    cyc(); idle_inputs();
    chk("R7 expected drop ignored", {status, stop_req, retry_pend}, 0);
    link_ready = 1; cyc(); link_down_ok = 0; cyc();

    // R8 retry deferred while device busy
    dev_busy = 1;
    lnk_err_vld = 1; lnk_cause = 3'b001; lnk_data_frm = 0;
    cyc(); idle_inputs();
    chk("R8 pend set", {retry_pend, retry_fire}, 2'b10);
    repeat (3) cyc();
    chk("R8 pend held while busy", {retry_pend, retry_fire}, 2'b10);
    dev_busy = 0;
    cyc();
    chk("R8 fire after busy drops", {retry_pend, retry_fire}, 2'b01);
    cyc();
    chk("R8 fire is one cycle", {retry_pend, retry_fire}, 2'b00);
    recover();

    // R9 sticky and write-one-to-clear
    mem_err_vld = 1; lnk_err_vld = 1; lnk_cause = 3'b010; lnk_data_frm = 0;
    cyc(); idle_inputs();
    chk("R9 two bits set", status, 4'b1001);
    clr_we = 1; clr_bits = 4'b0001; mem_err_vld = 1;
    cyc(); idle_inputs();
    chk("R9 coincident set wins", status, 4'b1001);
    clr_we = 1; clr_bits = 4'b0001;
    cyc(); idle_inputs();
    chk("R9 clear only masked bit", status, 4'b1000);
    clr_bits = 4'b1000;
    cyc();
    chk("R9 mask without strobe ignored", status, 4'b1000);
    recover();

    // R10 restart refused while fatal bit set
    mem_err_vld = 1;
    cyc(); idle_inputs();
    port_restart = 1;
    cyc(); idle_inputs();
    chk("R10 restart refused", stop_req, 1);
    clr_we = 1; clr_bits = 4'hF;
    cyc(); idle_inputs();
    chk("R10 clear alone keeps stop", stop_req, 1);
    port_restart = 1;
    cyc(); idle_inputs();
    chk("R10 restart after clear", stop_req, 0);
    cyc();

    // R11 enable gating and registered timing
    irq_en = 4'b0100;
    mem_err_vld = 1;
    cyc(); idle_inputs();
    chk("R11 irq lags status", irq, 0);
    cyc();
    chk("R11 disabled bit no irq", irq, 0);
    irq_en = 4'b0001;
    cyc(); cyc();
    chk("R11 enabled bit irq", irq, 1);
    gie = 0;
    cyc(); cyc();
    chk("R11 global enable off", irq, 0);
    gie = 1; irq_en = 4'hF;
    recover();
    cyc();
    chk("R11 irq drops after clear", irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule